// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a system watchdog reached through a byte-wide register port. Software places a 6-bit start value in a load register, clears a halt bit, and then refreshes the timer by writing the code 1 to the count address. A prescaler divides the clock into slow ticks; the nominal tick is 0.6 s, so a start value of 63 gives about 38 s. The count drops by one on each tick. A tick that finds the count at zero is an expiry, and the counter reloads itself from the load register.

Expiries come in two stages. The first one only raises a status flag and arms a pending stage. If a second expiry follows with no refresh in between, the block raises a second status flag and requests a system reset, unless the reset-inhibit bit is set. The reset request stays high until the watchdog's own reset arrives. A boot flag records that the reset was caused by the watchdog. This flag survives the watchdog reset and is cleared only by power-on reset or by software.

Top module: `wdog_two_stage`

Register map (byte addresses):

| Address | Contents |
|---|---|
| 0 | Count in bits 5:0; bits 7:6 read as 0. A write of exactly 1 is a refresh. |
| 1 | Load value in bits 5:0; bits 7:6 read as 0. |
| 2 | Status, write 1 to clear: bit 0 first expiry, bit 1 second expiry, bit 2 boot flag. |
| 3, 4 | 16-bit control word, low byte then high byte. Bit 11 (address 4, bit 3) is halt. |
| 5, 6 | 16-bit configuration word, low byte then high byte. Bit 10 (address 6, bit 2) is reset inhibit. |

## Requirements
- R1: After reset the count and the load value read 63, status reads 0, address 4 reads 0x08 (halted), address 6 reads 0x04 (inhibited) and the reset request is low. Bits 7:6 of addresses 0 and 1 always read 0, so writing 0xFF to address 1 reads back 0x3F.
- R2: While halt is clear, the count falls by one every TICK_CYCLES clocks. The first decrement comes TICK_CYCLES clocks after a refresh.
- R3: Writing 0x01 to address 0 loads the count from the load value and restarts the prescaler. This works even while the timer is halted. Any other value written to address 0 has no effect.
- R4: While halt (bit 11 of the control word) is set, the count does not change.
- R5: A tick at count 0 with no stage pending sets status bit 0, reloads the count from the load value, and leaves the reset request low. This happens (load+1)·TICK_CYCLES clocks after the refresh.
- R6: A tick at count 0 while the first stage is pending sets status bit 1. If inhibit is clear, it also raises the reset request, which then stays high until reset.
- R7: A refresh between two expiries clears the pending stage, so the next expiry counts as a first expiry.
- R8: While inhibit (bit 10 of the configuration word) is set, a second expiry sets status bit 1 but the reset request stays low.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: A watchdog reset taken while status bit 1 is set sets status bit 2. Status bit 2 survives later watchdog resets and is cleared by power-on reset or by a write of 1.
- R11: A refresh in the same cycle as an expiry wins: the count reloads and no status flag is set.
- R12: An expiry in the same cycle as a write-1-to-clear of its flag wins: the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything |
| rst | input | 1 | Watchdog-domain reset, synchronous, active high; keeps the boot flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| rst_req | output | 1 | Reset request, held until reset |

## Verification
Two pairs of events can fall in the same clock edge: a software refresh and a counter expiry, and a write-1-to-clear of the first-expiry flag and the expiry that sets it. The bench counts edges from a refresh so that each write lands exactly on the expiry edge. It then reads the status and the count to check that the refresh wins the first race (count reloaded, no flag) and that the set wins the second (flag high).

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int CNT_W  = 6;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [ADDR_W-1:0] {
        A_COUNT   = 3'd0,
        A_LOAD    = 3'd1,
        A_STAT    = 3'd2,
        A_CTRL_LO = 3'd3,
        A_CTRL_HI = 3'd4,
        A_CFG_LO  = 3'd5,
        A_CFG_HI  = 3'd6,
        A_SPARE   = 3'd7
    } reg_addr_e;

    localparam int STS_FIRST  = 0;
    localparam int STS_SECOND = 1;
    localparam int STS_BOOT   = 2;
    localparam int HALT_POS   = 3;  // bit 11 of the control word
    localparam int INH_POS    = 2;  // bit 10 of the configuration word

    localparam logic [DATA_W-1:0] REFRESH_CODE = 8'h01;
    localparam cnt_t CNT_TOP = '1;

    typedef struct packed {
        logic boot;
        logic second;
        logic first;
    } wd_status_t;

    function automatic logic [DATA_W-1:0] widen(cnt_t c);
        return {{(DATA_W-CNT_W){1'b0}}, c};
    endfunction
endpackage

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler #(
    parameter int TICK_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic srst,
    input  logic restart,
    output logic tick
);
    generate
        if (TICK_CYCLES <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(TICK_CYCLES);
            localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);
            logic [PW-1:0] phase;
            always_ff @(posedge clk) begin
                if (srst || restart || phase == LAST) phase <= '0;
                else                                  phase <= phase + 1'b1;
            end
            assign tick = (phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic srst,
    input  logic tick,
    input  logic halt,
    input  logic inhibit,
    input  logic refresh,
    input  cnt_t init_val,
    output cnt_t count,
    output logic first_evt,
    output logic second_evt,
    output logic rst_req
);
    logic stage;
    logic expire;

    assign expire     = tick && !halt && !refresh && (count == '0);
    assign first_evt  = expire && !stage;
    assign second_evt = expire && stage;

    always_ff @(posedge clk) begin
        if (srst) begin
            count   <= CNT_TOP;
            stage   <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (refresh) begin
                count <= init_val;
                stage <= 1'b0;
            end else if (tick && !halt) begin
                if (count == '0) begin
                    count <= init_val;
                    stage <= !stage;
                end else begin
                    count <= count - 1'b1;
                end
            end
            if (second_evt && !inhibit) rst_req <= 1'b1;
        end
    end

    p_dec_r2: assert property (@(posedge clk) disable iff (srst)
        (tick && !halt && !refresh && count != '0) |=> count == ($past(count) - cnt_t'(1)));
    p_refresh_r3: assert property (@(posedge clk) disable iff (srst)
        refresh |=> count == $past(init_val));
    p_halt_hold_r4: assert property (@(posedge clk) disable iff (srst)
        (halt && !refresh) |=> $stable(count));
    p_first_quiet_r5: assert property (@(posedge clk) disable iff (srst)
        first_evt |=> !$rose(rst_req));
    p_req_held_r6: assert property (@(posedge clk) disable iff (srst)
        rst_req |=> rst_req);
    p_inhibit_r8: assert property (@(posedge clk) disable iff (srst)
        $rose(rst_req) |-> $past(!inhibit && second_evt));
endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  cnt_t              count,
    input  logic              first_evt,
    input  logic              second_evt,
    output logic [DATA_W-1:0] rdata,
    output cnt_t              init_val,
    output logic              halt,
    output logic              inhibit,
    output logic              refresh
);
    logic       srst;
    reg_addr_e  sel;
    wd_status_t sts;
    logic       wr_stat;

    assign srst    = rst || por;
    assign sel     = reg_addr_e'(addr);
    assign wr_stat = wr_en && sel == A_STAT;
    assign refresh = wr_en && sel == A_COUNT && wdata == REFRESH_CODE;

    always_ff @(posedge clk) begin
        if (srst) begin
            init_val   <= CNT_TOP;
            halt       <= 1'b1;
            inhibit    <= 1'b1;
            sts.first  <= 1'b0;
            sts.second <= 1'b0;
        end else begin
            if (wr_en && sel == A_LOAD)    init_val <= wdata[CNT_W-1:0];
            if (wr_en && sel == A_CTRL_HI) halt     <= wdata[HALT_POS];
            if (wr_en && sel == A_CFG_HI)  inhibit  <= wdata[INH_POS];
            sts.first  <= first_evt  || (sts.first  && !(wr_stat && wdata[STS_FIRST]));
            sts.second <= second_evt || (sts.second && !(wr_stat && wdata[STS_SECOND]));
        end
    end

    // boot flag lives in the power-on domain
    always_ff @(posedge clk) begin
        if (por)                              sts.boot <= 1'b0;
        else if (rst && sts.second)           sts.boot <= 1'b1;
        else if (wr_stat && wdata[STS_BOOT])  sts.boot <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        case (sel)
            A_COUNT:   rdata = widen(count);
            A_LOAD:    rdata = widen(init_val);
            A_STAT:    rdata = {{(DATA_W-3){1'b0}}, sts};
            A_CTRL_HI: rdata[HALT_POS] = halt;
            A_CFG_HI:  rdata[INH_POS]  = inhibit;
            default:   rdata = '0;
        endcase
    end

    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (srst)
        (sel == A_COUNT || sel == A_LOAD) |-> rdata[DATA_W-1:CNT_W] == '0);
    p_w1c_r9: assert property (@(posedge clk) disable iff (srst)
        (wr_stat && wdata[STS_SECOND] && !second_evt) |=> !sts.second);
    p_boot_set_r10: assert property (@(posedge clk) disable iff (por)
        (rst && sts.second) |=> sts.boot);
    p_set_wins_r12: assert property (@(posedge clk) disable iff (srst)
        first_evt |=> sts.first);
endmodule

// File: rtl/wdog_two_stage.sv
`timescale 1ns/1ps
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int TICK_CYCLES = 30_000_000
) (
    input  logic       clk,
    input  logic       por,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rst_req
);
    logic srst;
    logic tick;
    logic halt;
    logic inhibit;
    logic refresh;
    logic first_evt;
    logic second_evt;
    cnt_t count;
    cnt_t init_val;

    assign srst = rst || por;

    wdog_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
        .clk     (clk),
        .srst    (srst),
        .restart (refresh),
        .tick    (tick)
    );

    wdog_core u_core (
        .clk        (clk),
        .srst       (srst),
        .tick       (tick),
        .halt       (halt),
        .inhibit    (inhibit),
        .refresh    (refresh),
        .init_val   (init_val),
        .count      (count),
        .first_evt  (first_evt),
        .second_evt (second_evt),
        .rst_req    (rst_req)
    );

    wdog_regs u_regs (
        .clk        (clk),
        .por        (por),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .count      (count),
        .first_evt  (first_evt),
        .second_evt (second_evt),
        .rdata      (rdata),
        .init_val   (init_val),
        .halt       (halt),
        .inhibit    (inhibit),
        .refresh    (refresh)
    );

    p_never_both_r6: assert property (@(posedge clk) disable iff (srst)
        !(first_evt && second_evt));
endmodule

// File: tb/test_wdog_two_stage.sv
`timescale 1ns/1ps
module test_wdog_two_stage;
    localparam int T = 4;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    wdog_two_stage #(.TICK_CYCLES(T)) i_wdog_two_stage (
        .clk(clk), .por(por), .rst(rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
    );

    function automatic int expiry_gap(int init);
        return (init + 1) * T;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic rchk(string req, logic [2:0] a, int exp);
        int v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse(bit power);
        if (power) por = 1'b1; else rst = 1'b1;
        @(negedge clk);
        por = 1'b0; rst = 1'b0;
    endtask

    // load, inhibit, unhalt, refresh; returns at the negedge after the refresh edge
    task automatic arm(int init, bit inh);
        wr(3'd1, 8'(init));
        wr(3'd6, inh ? 8'h04 : 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        por = 1'b0;
        @(negedge clk);

        // R1 reset state and reserved bits
        rchk("R1 count", 3'd0, 63);
        rchk("R1 load", 3'd1, 63);
        rchk("R1 status", 3'd2, 0);
        rchk("R1 ctrl", 3'd4, 8'h08);
        rchk("R1 cfg", 3'd6, 8'h04);
        chk("R1 req", int'(rst_req), 0);
        wr(3'd1, 8'hFF);
        rchk("R1 reserved", 3'd1, 8'h3F);

        // R3 and R4 while halted
        wr(3'd1, 8'd10);
        wr(3'd0, 8'h02);
        rchk("R3 ignored", 3'd0, 63);
        wr(3'd0, 8'h01);
        rchk("R3 refresh", 3'd0, 10);
        waitn(5 * T);
        rchk("R4 halt", 3'd0, 10);

        // R2 decrement timing
        arm(10, 1'b0);
        waitn(3 * T - 1);
        rchk("R2 two ticks", 3'd0, 8);
        waitn(1);
        rchk("R2 three ticks", 3'd0, 7);

        // R5 first expiry
        wr(3'd0, 8'h01);
        waitn(expiry_gap(10) - 1);
        rchk("R5 before", 3'd2, 0);
        waitn(1);
        rchk("R5 flag", 3'd2, 8'h01);
        rchk("R5 reload", 3'd0, 10);
        chk("R5 req", int'(rst_req), 0);

        // R6 second expiry
        waitn(expiry_gap(10) - 1);
        chk("R6 req early", int'(rst_req), 0);
        waitn(1);
        rchk("R6 flag", 3'd2, 8'h03);
        chk("R6 req", int'(rst_req), 1);

        // R9 write-1-to-clear
        wr(3'd2, 8'h00);
        rchk("R9 zero write", 3'd2, 8'h03);
        wr(3'd2, 8'h01);
        rchk("R9 clear", 3'd2, 8'h02);
        chk("R6 held", int'(rst_req), 1);

        // R10 boot flag across watchdog resets
        pulse(1'b0);
        rchk("R10 boot set", 3'd2, 8'h04);
        chk("R10 req cleared", int'(rst_req), 0);
        rchk("R10 count reset", 3'd0, 63);
        pulse(1'b0);
        rchk("R10 survives", 3'd2, 8'h04);
        wr(3'd2, 8'h04);
        rchk("R10 w1c", 3'd2, 0);

        // R8 inhibit
        arm(2, 1'b1);
        waitn(2 * expiry_gap(2));
        rchk("R8 flag", 3'd2, 8'h03);
        chk("R8 no req", int'(rst_req), 0);
        pulse(1'b0);
        rchk("R10 boot again", 3'd2, 8'h04);
        pulse(1'b1);
        rchk("R10 por clears", 3'd2, 0);

        // R7 refresh between expiries
        arm(3, 1'b0);
        waitn(expiry_gap(3));
        rchk("R7 first", 3'd2, 8'h01);
        wr(3'd0, 8'h01);
        waitn(expiry_gap(3));
        rchk("R7 treated first", 3'd2, 8'h01);
        chk("R7 no req", int'(rst_req), 0);
        waitn(expiry_gap(3));
        rchk("R7 then second", 3'd2, 8'h03);
        chk("R7 req", int'(rst_req), 1);
        pulse(1'b0);
        wr(3'd2, 8'h07);

        // R11 refresh on the expiry edge
        arm(5, 1'b0);
        waitn(expiry_gap(5) - 1);
        wr(3'd0, 8'h01);
        rchk("R11 no flag", 3'd2, 0);
        rchk("R11 reload", 3'd0, 5);

        // R12 clear on the expiry edge
        waitn(expiry_gap(5) - 1);
        wr(3'd2, 8'h01);
        rchk("R12 set wins", 3'd2, 8'h01);

        // R5 random load values and refresh patterns
        for (int it = 0; it < 8; it++) begin
            int init = int'($urandom % 16);
            int pings = int'($urandom % 3);
            wr(3'd2, 8'h03);
            wr(3'd1, 8'(init));
            wr(3'd0, 8'h01);
            for (int p = 0; p < pings; p++) begin
                waitn(int'($urandom % (expiry_gap(init) - 1)));
                wr(3'd0, 8'h01);
            end
            waitn(expiry_gap(init) - 1);
            rchk("R5 random before", 3'd2, 0);
            waitn(1);
            rchk("R5 random flag", 3'd2, 8'h01);
        end

        summary();
        $finish;
    end
endmodule